// File: doc/BRIEF.md
# Byte-Serial Frame Check Accelerator

This block is a register-mapped CRC engine used to check serial infrared frames. Software first clears it through a control register. It then writes frame bytes one at a time into a feed register. Each write folds one byte into a 16-bit frame check sequence register and adds one to a 12-bit count of the bytes absorbed. Software can read the count through the control register and the finished check value through a separate result register.

The engine uses the CCITT polynomial, processed least significant bit first (reflected constant 0x8408). The register is preset to all ones, and the result register returns the ones' complement of the internal register in natural bit order. A byte is absorbed in the clock edge that takes the write, so a read in the next cycle already returns the updated count and result. As a self-test, clearing the engine and feeding 0xCC, 0xF5, 0xF1, 0xA7 gives a count of 4 and a result of 0x51DF.

Top module: `fcs_engine`

## Requirements
- R1: After reset the control register (offset 0) reads 0x0000 and the result register (offset 2) reads 0x0000, which is the complement of the all-ones preset.
- R2: A write to the control register with bit 15 set clears the byte count to 0 and presets the CRC register to 0xFFFF. The next cycle the control register reads 0x0000 and the result register reads 0x0000.
- R3: A write to the control register with bit 15 clear changes neither the count nor the CRC.
- R4: A write to the feed register (offset 1) absorbs only bits 7:0 of the write data. Bits 15:8 have no effect on the result.
- R5: Each feed write adds one to the count. Bits 11:0 of the control register show the count and bits 15:12 read zero. The new count is visible on a read in the very next cycle.
- R6: The count saturates at 0xFFF. Further feed writes still update the CRC but leave the count at 0xFFF.
- R7: Each absorbed byte updates the CRC as follows: XOR the byte into the low 8 bits, then apply eight steps of shift-right with a conditional XOR of 0x8408. The result register reads the bitwise complement of the CRC, and the update is visible in the next cycle.
- R8: After a clear followed by the bytes 0xCC, 0xF5, 0xF1, 0xA7, the control register reads 0x0004 and the result register reads 0x51DF.
- R9: Offset 3 reads 0x0000, and writes to it change neither the count nor the CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register word offset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational from the current state |

## Verification
A wrong CRC state shows up in the result register on the read that follows the faulty byte. Because every later byte mixes the whole register, the error then persists to the end of the stream instead of cancelling out. A wrong count shows up on the next control read. A counter that wraps instead of saturating shows only at byte 4096, so a long saturation run is needed as well as the short random streams. Clear and ignored-write faults are exposed by reading both registers right after the write in question.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
    localparam int unsigned CRC_W  = 16;
    localparam int unsigned BUS_W  = 16;
    localparam int unsigned BYTE_W = 8;
    localparam logic [CRC_W-1:0] CRC_PRESET = 16'hFFFF;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'h8408;

    localparam logic [1:0] OFS_CTRL   = 2'd0;
    localparam logic [1:0] OFS_FEED   = 2'd1;
    localparam logic [1:0] OFS_RESULT = 2'd2;
    localparam int unsigned CLEAR_BIT = 15;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_FEED  = 2'd2
    } fcs_op_e;
endpackage

// File: rtl/fcs_byte_step.sv
module fcs_byte_step #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned NBITS = 8,
    parameter logic [WIDTH-1:0] POLY = 16'h8408
) (
    input  logic [WIDTH-1:0] crc_in,
    input  logic [NBITS-1:0] data_in,
    output logic [WIDTH-1:0] crc_out
);
    logic [WIDTH-1:0] stage [0:NBITS];

    assign stage[0] = crc_in ^ {{(WIDTH-NBITS){1'b0}}, data_in};

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        assign stage[i+1] = stage[i][0] ? ((stage[i] >> 1) ^ POLY)
                                        : (stage[i] >> 1);
    end

    assign crc_out = stage[NBITS];
endmodule

// File: rtl/fcs_sat_count.sv
module fcs_sat_count #(
    parameter int unsigned WIDTH = 12
) (
    input  logic [WIDTH-1:0] cnt_in,
    input  logic             bump,
    output logic [WIDTH-1:0] cnt_out
);
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    always_comb begin
        cnt_out = cnt_in;
        if (bump && (cnt_in != CNT_MAX)) begin
            cnt_out = cnt_in + 1'b1;
        end
    end
endmodule

// File: rtl/fcs_regmap.sv
module fcs_regmap
    import fcs_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic [BUS_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CRC_W-1:0] crc,
    output fcs_op_e          op,
    output logic [BUS_W-1:0] rdata
);
    always_comb begin
        op = OP_NONE;
        if (wr) begin
            if (addr == OFS_CTRL && wdata[CLEAR_BIT]) begin
                op = OP_CLEAR;
            end else if (addr == OFS_FEED) begin
                op = OP_FEED;
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_CTRL:   rdata = {{(BUS_W-CNT_W){1'b0}}, cnt};
            OFS_RESULT: rdata = ~crc;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
    import fcs_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CRC_W-1:0] crc;
        logic [CNT_W-1:0] cnt;
    } state_t;

    state_t  st_d, st_q;
    fcs_op_e op;
    logic [CRC_W-1:0] crc_step;
    logic [CNT_W-1:0] cnt_step;

    fcs_regmap #(.CNT_W(CNT_W)) u_map (
        .addr  (bus_addr),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .cnt   (st_q.cnt),
        .crc   (st_q.crc),
        .op    (op),
        .rdata (bus_rdata)
    );

    fcs_byte_step #(.WIDTH(CRC_W), .NBITS(BYTE_W), .POLY(CRC_POLY_REFL)) u_step (
        .crc_in  (st_q.crc),
        .data_in (bus_wdata[BYTE_W-1:0]),
        .crc_out (crc_step)
    );

    fcs_sat_count #(.WIDTH(CNT_W)) u_cnt (
        .cnt_in  (st_q.cnt),
        .bump    (1'b1),
        .cnt_out (cnt_step)
    );

    always_comb begin
        st_d = st_q;
        case (op)
            OP_CLEAR: begin
                st_d.crc = CRC_PRESET;
                st_d.cnt = '0;
            end
            OP_FEED: begin
                st_d.crc = crc_step;
                st_d.cnt = cnt_step;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.crc <= CRC_PRESET;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: a clear write leaves the preset and a zero count
    p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && bus_wdata[CLEAR_BIT])
        |=> (st_q.cnt == '0 && st_q.crc == CRC_PRESET));

    // R3: a control write without the clear bit changes nothing
    p_ctrl_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_CTRL && !bus_wdata[CLEAR_BIT])
        |=> ($stable(st_q.cnt) && $stable(st_q.crc)));

    // R5: a feed below the limit adds exactly one
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_FEED && st_q.cnt != CNT_MAX)
        |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R6: the count holds at its limit
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_FEED && st_q.cnt == CNT_MAX)
        |=> (st_q.cnt == CNT_MAX));

    // R9: idle cycles and writes to the spare offset keep the state
    p_spare_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || bus_addr == 2'd3)
        |=> ($stable(st_q.cnt) && $stable(st_q.crc)));
endmodule

// File: tb/sim_fcs_engine.sv
module sim_fcs_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_crc;
    logic [11:0] m_cnt;

    always #2 clk = ~clk;

    fcs_engine u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [15:0] ref_step(logic [15:0] c, logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) begin
            if (r[0]) r = (r >> 1) ^ 16'h8408;
            else      r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h, expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic feed(logic [15:0] d);
        bus_write(2'd1, d);
        m_crc = ref_step(m_crc, d[7:0]);
        if (m_cnt != 12'hFFF) m_cnt = m_cnt + 1'b1;
    endtask

    task automatic clear_model();
        bus_write(2'd0, 16'h8000);
        m_crc = 16'hFFFF;
        m_cnt = '0;
    endtask

    task automatic check_both(string rc, string rr);
        logic [15:0] v;
        bus_read(2'd0, v);
        check(rc, v, {4'h0, m_cnt});
        bus_read(2'd2, v);
        check(rr, v, ~m_crc);
    endtask

    initial begin
        logic [15:0] v;
        void'($urandom(32'd1357));
        m_crc = 16'hFFFF;
        m_cnt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, v); check("R1", v, 16'h0000);
        bus_read(2'd2, v); check("R1", v, 16'h0000);

        // R8 fixed self-test vector
        clear_model();
        feed(16'h00CC); feed(16'h00F5); feed(16'h00F1); feed(16'h00A7);
        bus_read(2'd0, v); check("R8", v, 16'h0004);
        bus_read(2'd2, v); check("R8", v, 16'h51DF);
        check("R8", ~m_crc, 16'h51DF);

        // R3 control write without the clear bit
        bus_write(2'd0, 16'h7FFF);
        check_both("R3", "R3");

        // R9 spare offset
        bus_write(2'd3, 16'hFFFF);
        bus_read(2'd3, v); check("R9", v, 16'h0000);
        check_both("R9", "R9");

        // R2 clear
        bus_write(2'd0, 16'h8000);
        bus_read(2'd0, v); check("R2", v, 16'h0000);
        bus_read(2'd2, v); check("R2", v, 16'h0000);
        m_crc = 16'hFFFF; m_cnt = '0;

        // R4 upper bits ignored
        feed(16'hAB12);
        check_both("R5", "R4");
        feed(16'hFF00);
        check_both("R5", "R4");

        // R7 / R5 random streams, checked after each byte
        for (int s = 0; s < 6; s++) begin
            int len;
            clear_model();
            len = 1 + int'($urandom_range(39));
            for (int i = 0; i < len; i++) begin
                feed(16'($urandom));
                check_both("R5", "R7");
            end
        end

        // R6 saturation
        clear_model();
        for (int i = 0; i < 4094; i++) feed({8'h00, 8'($urandom)});
        bus_read(2'd0, v); check("R6", v, 16'h0FFE);
        feed(16'h005A);
        check_both("R6", "R7");
        feed(16'h00C3);
        feed(16'h0011);
        bus_read(2'd0, v); check("R6", v, 16'h0FFF);
        bus_read(2'd2, v); check("R7", v, ~m_crc);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule